// File: doc/BRIEF.md
# Focal-Plane Array Clock Sequencer

This block produces the control lines for a large imaging array built from four identical quadrants. Each clock tick it emits one 32-bit control word. The upper half (bits 31..16) steers the top pair of quadrants and the lower half (bits 15..0) steers the bottom pair. In normal operation both halves carry the same 16-bit pattern, except that top bit 22 is unused and always driven low.

One start pulse runs a whole frame. The frame opens with a global reset. One tick then enables all rows and clears the fast multiplexer, and a further tick initialises the slow multiplexer. After that, every row pair gets the same sequence in order: a row-pair reset, one slow shift step, one fast shift step, an A/D convert strobe and a read strobe run. The read run length and its data-ready notification follow the programmed word count. The row count, word count and reset lengths are captured when the frame starts.

For array testing, a mirror-disable input hands the bottom half to an external pattern.

Top module: `fpa_seq_top`

## Requirements
- R1: During and right after reset, and in idle, the control word is 0x0100_0100. In that word only the drain-clamp bits 8 and 24 are high, because that line is active-low. `busy` and `data_ready` are 0.
- R2: While `mirror_off` is 0, `ctrl_word[31:16]` equals `ctrl_word[15:0]`, except that bit 22 (top copy of frame bit 6) is always 0.
- R3: Drain-clamp bit 8 is driven as the complement of its logical state. It reads 0 only during the global-reset phase and 1 in every other tick.
- R4: A frame begins with global reset, which lasts `greset_len`+1 ticks. In those ticks clamp-gate bit 0 and global-reset bit 3 are 1 and bit 8 is 0. Bits 0 and 3 are 1 in no other phase.
- R5: After global reset come one tick with row-disable bit 12 and fast-reset bit 13 both set (all rows enabled), then one tick with slow-init bit 7 set.
- R6: Each row pair begins with `rreset_len`+1 ticks in which row-reset bit 2 and row-on bit 1 are set together.
- R7: Slow stepping is bit 9 for one tick, one quiet tick, bit 10 for one tick, one quiet tick. Fast stepping follows the same pattern on bits 14 and 15. The two phases of one clock are never high together, and a phase-1 tick is never followed directly by phase 2.
- R8: A frame serves `row_count`+1 row pairs. During row pair r, odd/even bit 11 equals bit 0 of r.
- R9: Each row's convert bit 5 is high for exactly one tick, which is the tick directly before that row's read run.
- R10: Read bit 4 is high for exactly `word_count`+2 consecutive ticks per row. `data_ready` pulses for one tick, on the (`word_count`+1)-th of those ticks.
- R11: Frame bit 6 is 1 on every busy tick outside global reset. `busy` rises on the tick after `start` is sampled and falls after the last read tick.
- R12: `start` is ignored while busy. Changes to `row_count`, `word_count`, `greset_len` or `rreset_len` during a frame do not alter it.
- R13: While `mirror_off` is 1, `ctrl_word[15:0]` equals `bottom_override` and the top half keeps its sequencer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| row_count | input | ROW_W | Row pairs per frame minus one |
| word_count | input | WORD_W | Read words per row (read run is this plus two) |
| greset_len | input | LEN_W | Global reset length minus one |
| rreset_len | input | LEN_W | Row-pair reset length minus one |
| mirror_off | input | 1 | Test: bottom half taken from `bottom_override` |
| bottom_override | input | 16 | Test pattern for the bottom half |
| ctrl_word | output | 32 | Array control word, top half in bits 31..16 |
| busy | output | 1 | Frame in progress |
| data_ready | output | 1 | Notification one tick before the read run ends |

## Verification
The bench builds the block with ROW_W=3, WORD_W=4 and LEN_W=3, so a full frame lasts a few dozen ticks and several frames fit in one run. With WORD_W=4, a word count of 15 is the largest value the port can carry. Loading the read counter with 16 then tests that the counter is wide enough to hold the word count plus one. Word count 0 gives the shortest read run, where `data_ready` lands on the first of the two read ticks. Reset lengths of 0 and the maximum 7 exercise both ends of the phase timer.

// File: rtl/fpa_seq_pkg.sv
// Package fpa_seq_pkg
// Shared phase encoding and bit positions within one 16-bit half word.
// Assumes both halves use identical positions (top = bottom + 16).
package fpa_seq_pkg;

    localparam int HALF_W       = 16;
    localparam int B_CLAMP_GATE = 0;
    localparam int B_ROW_ON     = 1;
    localparam int B_ROW_RST    = 2;
    localparam int B_GLOB_RST   = 3;
    localparam int B_READ       = 4;
    localparam int B_CONVERT    = 5;
    localparam int B_FRAME      = 6;
    localparam int B_SLOW_INIT  = 7;
    localparam int B_DRAIN_N    = 8;
    localparam int B_SLOW_P1    = 9;
    localparam int B_SLOW_P2    = 10;
    localparam int B_ODD_EVEN   = 11;
    localparam int B_ROW_DIS    = 12;
    localparam int B_FAST_RST   = 13;
    localparam int B_FAST_P1    = 14;
    localparam int B_FAST_P2    = 15;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_GRST,
        PH_ENALL,
        PH_SINIT,
        PH_RRST,
        PH_SP1,
        PH_SGAP1,
        PH_SP2,
        PH_SGAP2,
        PH_FP1,
        PH_FGAP1,
        PH_FP2,
        PH_FGAP2,
        PH_CONV,
        PH_READ
    } phase_e;

endpackage

// File: rtl/fpa_seq_timer.sv
// Module fpa_seq_timer
// Down-counter that measures how long the current phase lasts. On load it takes
// the remaining-tick count minus one. It stops at zero.
// Assumes load and countdown never happen in the same tick (load wins).
module fpa_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero,
    output logic             at_one
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on phase entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flags for the last tick of a phase and the tick before it.
    always_comb begin
        at_zero = (cnt_q == '0);
        at_one  = (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/fpa_seq_fsm.sv
// Module fpa_seq_fsm
// Frame phase controller. It captures the configuration on start, walks the
// phase order and counts row pairs. It also raises the data-ready pulse on
// the second-to-last read tick.
// Assumes start is sampled only while idle.
module fpa_seq_fsm
    import fpa_seq_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int WORD_W = 10,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_count,
    input  logic [WORD_W-1:0] word_count,
    input  logic [LEN_W-1:0]  greset_len,
    input  logic [LEN_W-1:0]  rreset_len,
    output phase_e            phase,
    output logic              row_lsb,
    output logic              data_ready
);

    localparam int CNT_W = (LEN_W > WORD_W + 1) ? LEN_W : WORD_W + 1;

    phase_e            phase_q, phase_d;
    logic [ROW_W-1:0]  row_q, rows_q;
    logic [WORD_W-1:0] words_q;
    logic [LEN_W-1:0]  rlen_q;
    logic              t_zero, t_one;
    logic              advance;
    logic [CNT_W-1:0]  load_val;
    logic              last_row;

    fpa_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (load_val),
        .at_zero  (t_zero),
        .at_one   (t_one)
    );

    // Next phase: leave idle on start, otherwise step when the timer expires.
    always_comb begin
        last_row = (row_q == rows_q);
        phase_d  = phase_q;
        if (phase_q == PH_IDLE) begin
            if (start) phase_d = PH_GRST;
        end else if (t_zero) begin
            unique case (phase_q)
                PH_GRST:  phase_d = PH_ENALL;
                PH_ENALL: phase_d = PH_SINIT;
                PH_SINIT: phase_d = PH_RRST;
                PH_RRST:  phase_d = PH_SP1;
                PH_SP1:   phase_d = PH_SGAP1;
                PH_SGAP1: phase_d = PH_SP2;
                PH_SP2:   phase_d = PH_SGAP2;
                PH_SGAP2: phase_d = PH_FP1;
                PH_FP1:   phase_d = PH_FGAP1;
                PH_FGAP1: phase_d = PH_FP2;
                PH_FP2:   phase_d = PH_FGAP2;
                PH_FGAP2: phase_d = PH_CONV;
                PH_CONV:  phase_d = PH_READ;
                PH_READ:  phase_d = last_row ? PH_IDLE : PH_RRST;
                default:  phase_d = PH_IDLE;
            endcase
        end
        advance = (phase_d != phase_q);
    end

    // Timer reload value for the phase about to be entered (length minus one).
    always_comb begin
        unique case (phase_d)
            PH_GRST: load_val = CNT_W'(greset_len);
            PH_RRST: load_val = CNT_W'(rlen_q);
            PH_READ: load_val = CNT_W'(words_q) + CNT_W'(1);
            default: load_val = '0;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Configuration capture at frame start; held for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q  <= '0;
            words_q <= '0;
            rlen_q  <= '0;
        end else if (phase_q == PH_IDLE && start) begin
            rows_q  <= row_count;
            words_q <= word_count;
            rlen_q  <= rreset_len;
        end
    end

    // Row-pair index: cleared at frame start, bumped after each read run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (phase_q == PH_IDLE) begin
            row_q <= '0;
        end else if (phase_q == PH_READ && t_zero && !last_row) begin
            row_q <= row_q + 1'b1;
        end
    end

    // Outputs toward the encoder.
    always_comb begin
        phase      = phase_q;
        row_lsb    = row_q[0];
        data_ready = (phase_q == PH_READ) && t_one;
    end

endmodule

// File: rtl/fpa_seq_encode.sv
// Module fpa_seq_encode
// Decodes the current phase into one 16-bit half control word. The
// drain-clamp line is driven as its complement.
// Assumes the phase and row LSB come straight from registers.
module fpa_seq_encode
    import fpa_seq_pkg::*;
(
    input  phase_e              phase,
    input  logic                row_lsb,
    output logic [HALF_W-1:0]   half
);

    logic in_row;

    // Phase-to-line decode; bits not listed stay low.
    always_comb begin
        in_row = (phase inside {PH_RRST, PH_SP1, PH_SGAP1, PH_SP2, PH_SGAP2,
                                PH_FP1, PH_FGAP1, PH_FP2, PH_FGAP2,
                                PH_CONV, PH_READ});
        half = '0;
        half[B_DRAIN_N]  = 1'b1;
        half[B_FRAME]    = (phase != PH_IDLE) && (phase != PH_GRST);
        half[B_ODD_EVEN] = in_row && row_lsb;
        unique case (phase)
            PH_GRST: begin
                half[B_CLAMP_GATE] = 1'b1;
                half[B_GLOB_RST]   = 1'b1;
                half[B_DRAIN_N]    = 1'b0;
            end
            PH_ENALL: begin
                half[B_ROW_DIS]  = 1'b1;
                half[B_FAST_RST] = 1'b1;
            end
            PH_SINIT: half[B_SLOW_INIT] = 1'b1;
            PH_RRST: begin
                half[B_ROW_RST] = 1'b1;
                half[B_ROW_ON]  = 1'b1;
            end
            PH_SP1:  half[B_SLOW_P1] = 1'b1;
            PH_SP2:  half[B_SLOW_P2] = 1'b1;
            PH_FP1:  half[B_FAST_P1] = 1'b1;
            PH_FP2:  half[B_FAST_P2] = 1'b1;
            PH_CONV: half[B_CONVERT] = 1'b1;
            PH_READ: half[B_READ]    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fpa_seq_mirror.sv
// Module fpa_seq_mirror
// Places the half word on both halves of the control bus. It forces the
// unused top bit low and can substitute a test pattern on the bottom half.
// Assumes the unused position is the frame bit of the top half.
module fpa_seq_mirror
    import fpa_seq_pkg::*;
(
    input  logic [HALF_W-1:0]   half,
    input  logic                mirror_off,
    input  logic [HALF_W-1:0]   bottom_override,
    output logic [2*HALF_W-1:0] ctrl_word
);

    // Top half mirrors with its unused bit cleared; bottom may be overridden.
    always_comb begin
        ctrl_word[2*HALF_W-1:HALF_W] = half;
        ctrl_word[HALF_W + B_FRAME]  = 1'b0;
        ctrl_word[HALF_W-1:0]        = mirror_off ? bottom_override : half;
    end

endmodule

// File: rtl/fpa_seq_top.sv
// Module fpa_seq_top
// Focal-plane array clock sequencer: a phase controller, a half-word
// decoder and a top/bottom mirror stage.
// Assumes the configuration is stable in the tick start is sampled.
module fpa_seq_top
    import fpa_seq_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int WORD_W = 10,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_count,
    input  logic [WORD_W-1:0] word_count,
    input  logic [LEN_W-1:0]  greset_len,
    input  logic [LEN_W-1:0]  rreset_len,
    input  logic              mirror_off,
    input  logic [15:0]       bottom_override,
    output logic [31:0]       ctrl_word,
    output logic              busy,
    output logic              data_ready
);

    phase_e            phase;
    logic              row_lsb;
    logic [HALF_W-1:0] half;

    fpa_seq_fsm #(.ROW_W(ROW_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .row_count  (row_count),
        .word_count (word_count),
        .greset_len (greset_len),
        .rreset_len (rreset_len),
        .phase      (phase),
        .row_lsb    (row_lsb),
        .data_ready (data_ready)
    );

    fpa_seq_encode u_enc (
        .phase   (phase),
        .row_lsb (row_lsb),
        .half    (half)
    );

    fpa_seq_mirror u_mir (
        .half            (half),
        .mirror_off      (mirror_off),
        .bottom_override (bottom_override),
        .ctrl_word       (ctrl_word)
    );

    // Busy whenever a frame phase is active.
    always_comb busy = (phase != PH_IDLE);

endmodule

// File: rtl/fpa_seq_checker.sv
// Module fpa_seq_checker
// Temporal properties of the sequencer, observed at the top-level ports.
// Assumes it is bound into every fpa_seq_top instance.
module fpa_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_word,
    input logic        busy,
    input logic        data_ready,
    input logic        mirror_off
);

    // R2: halves match apart from the forced-low unused bit
    p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mirror_off |-> (ctrl_word[31:23] == ctrl_word[15:7]) &&
                        (ctrl_word[21:16] == ctrl_word[5:0]) && !ctrl_word[22]);

    // R3: drain clamp low only together with global reset (top half)
    p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[24] |-> ctrl_word[19] && ctrl_word[16]);

    // R7: slow and fast phases never overlap
    p_phase_sep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_word[25] && ctrl_word[26]) && !(ctrl_word[30] && ctrl_word[31]));

    // R7: a quiet tick follows every phase-1 pulse
    p_phase_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[25] || ctrl_word[30]) |=> !ctrl_word[26] && !ctrl_word[31]);

    // R9: a read run always starts right after a convert tick
    p_conv_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_word[20]) |-> $past(ctrl_word[21]));

    // R10: data-ready sits inside the read run with one read tick after it
    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> ctrl_word[20] ##1 (ctrl_word[20] && !data_ready));

    // R11: idle word on the top half whenever not busy
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ctrl_word[31:16] == 16'h0100) && !data_ready);

endmodule

bind fpa_seq_top fpa_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl_word),
    .busy       (busy),
    .data_ready (data_ready),
    .mirror_off (mirror_off)
);

// File: tb/tb_fpa_seq_top.sv
module tb_fpa_seq_top;

    localparam int ROW_W  = 3;
    localparam int WORD_W = 4;
    localparam int LEN_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [ROW_W-1:0]  row_count;
    logic [WORD_W-1:0] word_count;
    logic [LEN_W-1:0]  greset_len;
    logic [LEN_W-1:0]  rreset_len;
    logic              mirror_off;
    logic [15:0]       bottom_override;
    logic [31:0]       ctrl_word;
    logic              busy;
    logic              data_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [15:0] q_half[$];
    bit          q_dr[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    fpa_seq_top #(.ROW_W(ROW_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_count(row_count),
        .word_count(word_count), .greset_len(greset_len), .rreset_len(rreset_len),
        .mirror_off(mirror_off), .bottom_override(bottom_override),
        .ctrl_word(ctrl_word), .busy(busy), .data_ready(data_ready)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] base(input bit frame, input bit oe);
        logic [15:0] v;
        v = 16'h0100;
        v[6] = frame;
        v[11] = oe;
        return v;
    endfunction

    task automatic push(input logic [15:0] h, input bit dr, input string tag);
        q_half.push_back(h);
        q_dr.push_back(dr);
        q_tag.push_back(tag);
    endtask

    // Reference model: expected half word, one entry per tick of the frame.
    task automatic build(input int rows, input int words, input int gl, input int rl);
        for (int i = 0; i <= gl; i++) push(16'h0009, 1'b0, "R4 R3");
        push(base(1, 0) | 16'h3000, 1'b0, "R5");
        push(base(1, 0) | 16'h0080, 1'b0, "R5");
        for (int r = 0; r <= rows; r++) begin
            logic [15:0] b;
            b = base(1, r[0]);
            for (int i = 0; i <= rl; i++) push(b | 16'h0006, 1'b0, "R6 R8");
            push(b | 16'h0200, 1'b0, "R7 R8");
            push(b, 1'b0, "R7");
            push(b | 16'h0400, 1'b0, "R7");
            push(b, 1'b0, "R7");
            push(b | 16'h4000, 1'b0, "R7");
            push(b, 1'b0, "R7");
            push(b | 16'h8000, 1'b0, "R7");
            push(b, 1'b0, "R7");
            push(b | 16'h0020, 1'b0, "R9");
            for (int k = 1; k <= words + 2; k++) push(b | 16'h0010, (k == words + 1), "R10");
        end
    endtask

    task automatic check_idle(input string tag);
        check(ctrl_word[31:16] == 16'h0100, {tag, " R1 idle top"}, ctrl_word, 32'h01000100);
        check(mirror_off || ctrl_word[15:0] == 16'h0100, {tag, " R1 idle bottom"}, ctrl_word, 32'h01000100);
        check(!busy && !data_ready, {tag, " R11 idle flags"}, {30'd0, busy, data_ready}, 32'd0);
    endtask

    task automatic run(input int rows, input int words, input int gl, input int rl,
                       input bit disturb, input string label);
        int idx = 0;
        row_count  = ROW_W'(rows);
        word_count = WORD_W'(words);
        greset_len = LEN_W'(gl);
        rreset_len = LEN_W'(rl);
        start      = 1'b1;
        build(rows, words, gl, rl);
        @(negedge clk);
        start = 1'b0;
        while (q_half.size() > 0) begin
            logic [15:0] h;
            logic [31:0] expw;
            h = q_half.pop_front();
            expw = {h & 16'hFFBF, h};
            check(ctrl_word[31:16] == expw[31:16], {label, " R2 top ", q_tag[0]}, ctrl_word, expw);
            if (mirror_off)
                check(ctrl_word[15:0] == bottom_override, {label, " R13 bottom"}, ctrl_word, {expw[31:16], bottom_override});
            else
                check(ctrl_word[15:0] == h, {label, " bottom ", q_tag[0]}, ctrl_word, expw);
            check(busy == 1'b1, {label, " R11 busy"}, {31'd0, busy}, 32'd1);
            check(data_ready == q_dr[0], {label, " R10 data_ready"}, {31'd0, data_ready}, {31'd0, q_dr[0]});
            void'(q_dr.pop_front());
            void'(q_tag.pop_front());
            idx++;
            if (disturb && idx == 5) begin
                start      = 1'b1;
                row_count  = '1;
                word_count = 4'd2;
                rreset_len = 3'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check_idle({label, " R12 end"});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        row_count = '0;
        word_count = '0;
        greset_len = '0;
        rreset_len = '0;
        mirror_off = 1'b0;
        bottom_override = 16'h0000;
        repeat (3) @(negedge clk);
        check(ctrl_word == 32'h01000100 && !busy && !data_ready, "R1 in reset", ctrl_word, 32'h01000100);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        run(1, 0, 2, 0, 1'b0, "frameA");
        @(negedge clk);
        run(2, 15, 0, 7, 1'b1, "frameB R12");
        @(negedge clk);

        mirror_off = 1'b1;
        bottom_override = 16'hA5C3;
        @(negedge clk);
        check(ctrl_word[15:0] == 16'hA5C3, "R13 idle override", ctrl_word, 32'h0100A5C3);
        check(ctrl_word[31:16] == 16'h0100, "R13 idle top", ctrl_word, 32'h0100A5C3);
        run(0, 1, 1, 0, 1'b0, "frameC R13");
        mirror_off = 1'b0;
        @(negedge clk);
        check_idle("R2 restore");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule